// File: doc/BRIEF.md
# Multi-format serial audio input deserializer

This block takes four serial audio lines that share one word clock and one bit clock. Each line carries one stereo pair, so there are eight channels in all. For every sample period the block produces eight parallel sample words. The bit clock comes from outside and runs at 64 times the word rate. Each half of the word clock (one channel) therefore spans 32 bit slots. Data is sent MSB first and changes on the falling bit-clock edge. The block samples it on the rising edge, which is the middle of each bit period.

A 4-bit format code selects the sample length (16, 18, 20, 22 or 24 bits) and the justification. The code can also select mute, and some code values are reserved. A polarity input chooses which word-clock edge opens a period. Four user bits are taken once per period, at the word-clock edge that closes the right channel. A one-cycle strobe then presents all eight samples and the user bits together. Every sample is delivered as a 24-bit word aligned to the MSB, with the unused low bits cleared.

Top module: `sdin_deser`

## Requirements
- R1: Format codes 0, 1, 2 and 3 select right-justified words of 16, 18, 20 and 22 bits, with the LSB in the last (32nd) slot of the channel half.
- R2: Format codes 4, 5, 6 and 7 select left-justified words of 16, 18, 20 and 22 bits, with the MSB in the first slot of the channel half.
- R3: Code 12 selects a right-justified 24-bit word. Code 13 selects a left-justified 24-bit word.
- R4: Code 15 (mute) and the reserved codes 8, 9, 10, 11 and 14 produce all-zero samples, whatever the data lines carry.
- R5: With `wclk_pol_i` low, a rising word-clock edge opens a period and the left half is word-clock high. With `wclk_pol_i` high, a falling edge opens the period and the left half is word-clock low.
- R6: In the first half of a period each line carries its left (odd) channel; in the second half it carries its right (even) channel. Line k left appears at `samples_o[48k+23:48k]` and line k right at `samples_o[48k+47:48k+24]`.
- R7: Serial data and the word clock are sampled on the rising edge of `bclk_i`, the middle of a bit period whose data changes on the falling edge.
- R8: Each sample is output MSB-aligned in 24 bits, with the bits below the selected width at zero, even when the unused slots carry ones.
- R9: `user_i` is sampled at the word-clock edge that closes the right half (the opening edge of the next period) and appears on `user_o` together with that period's samples.
- R10: `valid_o` is high for exactly one bit-clock cycle per complete period, in the cycle after the closing word-clock edge is sampled. `samples_o` and `user_o` change only in that cycle.
- R11: The active-low asynchronous reset clears `samples_o`, `user_o` and `valid_o`. After reset, no strobe comes until a full 64-slot period has run from a qualifying word-clock edge.
- R12: The format code is latched at the opening edge of a period. A change of `fmt_i` later in that period does not affect that period's decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock, 64 times the word rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | Word clock |
| wclk_pol_i | input | 1 | Period-opening edge select: 0 rising, 1 falling |
| fmt_i | input | 4 | Format code |
| sdata_i | input | 4 | Serial data, one line per stereo pair |
| user_i | input | 4 | User bits |
| samples_o | output | 192 | Eight 24-bit MSB-aligned samples |
| user_o | output | 4 | User bits captured with the current samples |
| valid_o | output | 1 | One-cycle frame strobe |

## Verification
All sixteen format codes are tried with distinct sample patterns on every channel. The slots a format does not use are driven with ones. This catches a wrong justification, a wrong width or missing zero fill: each of those would let stray ones, or a shifted value, reach the output. One period changes the format code in its second half, which separates latching at the period boundary from decoding live. A run with the opposite word-clock polarity, and a reset in the middle of the stream, show whether the opening edge is chosen correctly and whether the first strobe is held back until a full period has run.

// File: rtl/sdin_pkg.sv
package sdin_pkg;
  localparam int OUT_W  = 24;
  localparam int HALF_W = 32;
  localparam int FMT_W  = 4;

  typedef struct packed {
    logic       en;
    logic       ljust;
    logic [4:0] width;
  } fmt_mode_t;

  function automatic fmt_mode_t decode_fmt(input logic [FMT_W-1:0] code);
    fmt_mode_t m;
    m = '0;
    if (!code[3]) begin
      m.en    = 1'b1;
      m.ljust = code[2];
      m.width = 5'd16 + {2'b00, code[1:0], 1'b0};
    end else if (code[3:1] == 3'b110) begin
      m.en    = 1'b1;
      m.ljust = code[0];
      m.width = 5'd24;
    end
    return m;
  endfunction

  // raw[HALF_W-1] holds the first slot of the half
  function automatic logic [OUT_W-1:0] align_sample(input logic [HALF_W-1:0] raw,
                                                    input fmt_mode_t m);
    logic [OUT_W-1:0] r;
    if (!m.en)
      r = '0;
    else if (m.ljust)
      r = raw[HALF_W-1 -: OUT_W] & ~({OUT_W{1'b1}} >> m.width);
    else
      r = raw[OUT_W-1:0] << (5'd24 - m.width);
    return r;
  endfunction
endpackage

// File: rtl/sdin_frame_timer.sv
module sdin_frame_timer
  import sdin_pkg::*;
#(
  parameter int USER_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic              pol_i,
  input  logic [FMT_W-1:0]  fmt_i,
  input  logic [USER_W-1:0] user_i,
  output logic              cap_left_o,
  output logic              frame_done_o,
  output fmt_mode_t         mode_o,
  output logic              valid_o,
  output logic [USER_W-1:0] user_o
);
  localparam int PERIOD = 2 * HALF_W;
  localparam int SLOT_W = $clog2(PERIOD) + 1;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic              wclk_q, seen_q, armed_q;
  logic [SLOT_W-1:0] slot_q;
  logic [FMT_W-1:0]  fmt_q;
  logic              start;

  assign start        = seen_q && (wclk_i != wclk_q) && (wclk_i == ~pol_i);
  assign cap_left_o   = !start && (slot_q == SLOT_W'(HALF_W));
  assign frame_done_o = start && armed_q && (slot_q == SLOT_W'(PERIOD));
  assign mode_o       = decode_fmt(fmt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q  <= 1'b0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
      slot_q  <= '0;
      fmt_q   <= '0;
      valid_o <= 1'b0;
      user_o  <= '0;
    end else begin
      wclk_q  <= wclk_i;
      seen_q  <= 1'b1;
      valid_o <= frame_done_o;
      if (frame_done_o) user_o <= user_i;
      if (start) begin
        armed_q <= 1'b1;
        slot_q  <= SLOT_W'(1);
        fmt_q   <= fmt_i;
      end else if (slot_q != SLOT_MAX) begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdin_lane.sv
module sdin_lane
  import sdin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             cap_left_i,
  input  logic             done_i,
  input  fmt_mode_t        mode_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o
);
  logic [HALF_W-1:0] shift_q, left_raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q    <= '0;
      left_raw_q <= '0;
      left_o     <= '0;
      right_o    <= '0;
    end else begin
      shift_q <= {shift_q[HALF_W-2:0], sdata_i};
      if (cap_left_i) left_raw_q <= shift_q;
      if (done_i) begin
        left_o  <= align_sample(left_raw_q, mode_i);
        right_o <= align_sample(shift_q, mode_i);
      end
    end
  end
endmodule

// File: rtl/sdin_deser.sv
module sdin_deser
  import sdin_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int USER_W = 4
) (
  input  logic                       bclk_i,
  input  logic                       rst_ni,
  input  logic                       wclk_i,
  input  logic                       wclk_pol_i,
  input  logic [FMT_W-1:0]           fmt_i,
  input  logic [LINES-1:0]           sdata_i,
  input  logic [USER_W-1:0]          user_i,
  output logic [2*LINES*OUT_W-1:0]   samples_o,
  output logic [USER_W-1:0]          user_o,
  output logic                       valid_o
);
  logic      cap_left, frame_done;
  fmt_mode_t mode;

  sdin_frame_timer #(.USER_W(USER_W)) timer_i (
    .clk_i       (bclk_i),
    .rst_ni      (rst_ni),
    .wclk_i      (wclk_i),
    .pol_i       (wclk_pol_i),
    .fmt_i       (fmt_i),
    .user_i      (user_i),
    .cap_left_o  (cap_left),
    .frame_done_o(frame_done),
    .mode_o      (mode),
    .valid_o     (valid_o),
    .user_o      (user_o)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_lane
    sdin_lane lane_i (
      .clk_i     (bclk_i),
      .rst_ni    (rst_ni),
      .sdata_i   (sdata_i[g]),
      .cap_left_i(cap_left),
      .done_i    (frame_done),
      .mode_i    (mode),
      .left_o    (samples_o[(2*g)*OUT_W +: OUT_W]),
      .right_o   (samples_o[(2*g+1)*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/sdin_deser_chk.sv
module sdin_deser_chk
  import sdin_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int USER_W = 4
) (
  input logic                     bclk_i,
  input logic                     rst_ni,
  input logic [2*LINES*OUT_W-1:0] samples_o,
  input logic [USER_W-1:0]        user_o,
  input logic                     valid_o
);
  logic [6:0] gap_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= '0;
    else if (valid_o)    gap_q <= '0;
    else if (gap_q != '1) gap_q <= gap_q + 7'd1;
  end

  // R10: strobe lasts one cycle
  assert_valid_pulse_R10: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R10: samples move only with the strobe
  assert_samples_hold_R10: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(samples_o));

  // R9: user bits move only with the strobe
  assert_user_hold_R9: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(user_o));

  // R11: strobes at least one full period apart, also after reset
  assert_period_gap_R11: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    valid_o |-> gap_q >= 7'd63);

  always @(posedge bclk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R11: assert (!valid_o && samples_o == '0 && user_o == '0);
    end
  end
endmodule

bind sdin_deser sdin_deser_chk #(.LINES(LINES), .USER_W(USER_W)) chk_i (
  .bclk_i   (bclk_i),
  .rst_ni   (rst_ni),
  .samples_o(samples_o),
  .user_o   (user_o),
  .valid_o  (valid_o)
);

// File: tb/sdin_deser_tb_top.sv
module sdin_deser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  // {fmt, user, base sample}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h01A5C3E1, 32'h1F7E2D4B, 32'h2336A99C, 32'h34F0F00F,
    32'h48C1B2A3, 32'h5B5A5A5A, 32'h6E123456, 32'h7DFEDCBA,
    32'hC9ABCDEF, 32'hD2801357, 32'hF5FFFFFF, 32'h8A777777,
    32'h96135799, 32'hA3AAAAAA, 32'hBC0F0F0F, 32'hE1C0FFEE
  };

  logic         bclk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wclk_i = 1'b0;
  logic         wclk_pol_i = 1'b0;
  logic [3:0]   fmt_i = '0;
  logic [3:0]   sdata_i = '0;
  logic [3:0]   user_i = '0;
  logic [191:0] samples_o;
  logic [3:0]   user_o;
  logic         valid_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [23:0] prev_exp [8];
  logic [3:0]  prev_user;
  string       prev_tag;
  bit          have_prev = 1'b0;

  always #(CLK_PERIOD/2) bclk = ~bclk;

  sdin_deser dut_i (
    .bclk_i    (bclk),
    .rst_ni    (rst_ni),
    .wclk_i    (wclk_i),
    .wclk_pol_i(wclk_pol_i),
    .fmt_i     (fmt_i),
    .sdata_i   (sdata_i),
    .user_i    (user_i),
    .samples_o (samples_o),
    .user_o    (user_o),
    .valid_o   (valid_o)
  );

  function automatic int fw(input logic [3:0] f);
    case (f)
      4'd0, 4'd4: return 16;
      4'd1, 4'd5: return 18;
      4'd2, 4'd6: return 20;
      4'd3, 4'd7: return 22;
      4'd12, 4'd13: return 24;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_lj(input logic [3:0] f);
    return (f >= 4'd4 && f <= 4'd7) || f == 4'd13;
  endfunction

  function automatic logic [23:0] sval(input logic [23:0] base, input int ch);
    return base ^ 24'(ch * 32'h0002D1B3 + ch * ch * 32'h51);
  endfunction

  function automatic logic [23:0] exp_of(input logic [3:0] f, input logic [23:0] v);
    int w = fw(f);
    if (w == 0) return '0;
    return v & ~(24'hFFFFFF >> w);
  endfunction

  // j: slot within the half, 0 first
  function automatic logic enc_bit(input logic [3:0] f, input logic [23:0] v, input int j);
    int w = fw(f);
    if (w == 0) return v[j % 24];
    if (is_lj(f)) return (j < w) ? v[23-j] : 1'b1;
    return (j >= 32 - w) ? v[24 - w + 31 - j] : 1'b1;
  endfunction

  function automatic string cls(input logic [3:0] f);
    if (f < 4'd4) return "R1";
    if (f < 4'd8) return "R2";
    if (f == 4'd12 || f == 4'd13) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_prev();
    if (!have_prev) begin
      chk("R11 no strobe before a full period", {31'd0, valid_o}, 32'd0);
    end else begin
      chk("R10 strobe after closing edge", {31'd0, valid_o}, 32'd1);
      for (int c = 0; c < 8; c++)
        chk($sformatf("%s R6 R7 R8 ch%0d", prev_tag, c), {8'd0, samples_o[c*24 +: 24]}, {8'd0, prev_exp[c]});
      chk("R9 user bits", {28'd0, user_o}, {28'd0, prev_user});
    end
  endtask

  task automatic send_period(input logic [3:0] f, input logic [3:0] f_late, input bit pol,
                             input logic [3:0] usr, input logic [23:0] base, input string tag);
    logic [23:0] v [8];
    for (int c = 0; c < 8; c++) v[c] = sval(base, c);
    for (int s = 0; s < 64; s++) begin
      @(negedge bclk);
      if (s == 1) check_prev();
      wclk_i = (s < 32) ? ~pol : pol;
      fmt_i  = (s >= 40) ? f_late : f;
      if (s == 32) user_i = usr;
      for (int k = 0; k < 4; k++)
        sdata_i[k] = enc_bit(f, v[2*k + (s >= 32 ? 1 : 0)], s % 32);
    end
    for (int c = 0; c < 8; c++) prev_exp[c] = exp_of(f, v[c]);
    prev_user = usr;
    prev_tag  = tag;
    have_prev = 1'b1;
  endtask

  task automatic do_reset(input bit pol);
    @(negedge bclk);
    rst_ni = 1'b0;
    wclk_pol_i = pol;
    wclk_i = pol;
    #1;
    chk("R11 reset clears strobe", {31'd0, valid_o}, 32'd0);
    chk("R11 reset clears samples", {31'd0, |samples_o}, 32'd0);
    chk("R11 reset clears user", {28'd0, user_o}, 32'd0);
    repeat (3) @(negedge bclk);
    rst_ni = 1'b1;
    repeat (3) @(negedge bclk);
    have_prev = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset(1'b0);

    // all codes, rising-edge periods
    for (int i = 0; i < NVEC; i++)
      send_period(VEC[i][31:28], VEC[i][31:28], 1'b0, VEC[i][27:24], VEC[i][23:0], cls(VEC[i][31:28]));

    // R12: code flips to mute in the second half, decode stays left-justified 18
    send_period(4'd5, 4'd15, 1'b0, 4'h6, 24'h3C5A96, "R12");
    send_period(4'd15, 4'd15, 1'b0, 4'h9, 24'h123456, "R4");
    send_period(4'd2, 4'd2, 1'b0, 4'h3, 24'hDEADBE, "R1");

    // reset mid-stream with live outputs, then falling-edge periods
    do_reset(1'b1);
    send_period(4'd13, 4'd13, 1'b1, 4'hA, 24'h9ABCDE, "R5 R3");
    send_period(4'd3, 4'd3, 1'b1, 4'h5, 24'h246813, "R5 R1");
    send_period(4'd6, 4'd6, 1'b1, 4'hC, 24'hF1E2D3, "R5 R2");
    send_period(4'd12, 4'd12, 1'b1, 4'h0, 24'h000000, "R5 R3");

    summary();
    $finish;
  end
endmodule